// File: doc/BRIEF.md
# Lane-Partitioned 128-bit SIMD ALU

This block is a registered 128-bit vector arithmetic unit for the execute stage of a wide-register pipeline. Each request carries two 128-bit operands, an operation code, a lane-size select and a destination register index. The 128-bit path is split into independent lanes of 8, 16 or 32 bits. Within each lane the block adds or subtracts with wrap-around, or compares two signed values and returns a lane mask. Bitwise AND, OR, XOR and NOR cover the whole word and ignore the lane size.

The result is registered and appears one cycle after the request, together with a write-enable and the destination index for the register file. Destination index zero is treated as a discard target, so such a request completes with its write-enable held low. An operation code the block does not implement, or a lane-sized operation with no valid lane size, returns a zero result and raises a one-cycle illegal-operation flag.

Top module: `simd_lane_alu`

## Requirements
- R1: After reset all outputs are zero. `res_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low after an edge that sampled it low. `res_data`, `res_we`, `res_idx` and `illegal_op` are updated together with it.
- R2: With `op` = 0 (add), each lane of `res_data` equals the sum of the matching lanes of `src_a` and `src_b`, taken modulo 2^lane width. No carry crosses into the next lane.
- R3: With `op` = 1 (subtract), each lane is `src_a` minus `src_b`, taken modulo 2^lane width. No borrow crosses into the next lane.
- R4: With `op` = 2, 3, 4 or 5, `res_data` is the 128-bit AND, OR, XOR or NOR of the operands, in that order, for every value of `lane_sel` including 3.
- R5: With `op` = 6, every lane where signed `src_a` is greater than signed `src_b` becomes all ones, and every other lane becomes all zeros.
- R6: With `op` = 7, every lane where the operands are equal becomes all ones, and every other lane becomes all zeros.
- R7: `lane_sel` 0, 1 and 2 select 8-, 16- and 32-bit lanes. A lane-sized operation (`op` 0, 1, 6 or 7) with `lane_sel` = 3 is illegal.
- R8: A request with `dst_idx` = 0 still raises `res_valid`, but `res_we` stays low. Any other index gives `res_we` high.
- R9: An illegal request, meaning `op` 8 to 15 or the case in R7, produces `res_data` = 0 and `illegal_op` high for that one result cycle only. `res_we` still follows R8.
- R10: `res_idx` equals the `dst_idx` of the request that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| lane_sel | input | 2 | Lane size: 0=8, 1=16, 2=32 bits |
| dst_idx | input | 5 | Destination register index |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| res_valid | output | 1 | Result present this cycle |
| res_we | output | 1 | Register-file write-enable |
| res_idx | output | 5 | Destination index of the result |
| res_data | output | 128 | Result word |
| illegal_op | output | 1 | Request was not a supported operation |

## Verification
Every result, flag and index is due exactly one clock edge after the request is sampled, and no output has any other latency. The bench drives each request on a falling edge and holds it across one rising edge. It drops `in_valid` on the next falling edge and samples all outputs at that same moment, so it reads the registered result of that request and nothing later. An idle cycle is checked the same way, to show that `res_valid` returns low. The illegal flag is checked again on the request that follows, to show that it clears.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DW    = 128,
  parameter int LANE0 = 8,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [1:0]    lane_sel,
  input  logic [IW-1:0] dst_idx,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic          res_valid,
  output logic          res_we,
  output logic [IW-1:0] res_idx,
  output logic [DW-1:0] res_data,
  output logic          illegal_op
);
  localparam int NSZ = 3;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_NOR = 4'd5, OP_GT = 4'd6, OP_EQ = 4'd7;

  logic [NSZ:0][DW-1:0] add_v, sub_v, gt_v, eq_v;
  assign add_v[NSZ] = '0;
  assign sub_v[NSZ] = '0;
  assign gt_v[NSZ]  = '0;
  assign eq_v[NSZ]  = '0;

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int LW = LANE0 << g;
    localparam int NL = DW / LW;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      wire [LW-1:0] la = src_a[i*LW +: LW];
      wire [LW-1:0] lb = src_b[i*LW +: LW];
      assign add_v[g][i*LW +: LW] = la + lb;
      assign sub_v[g][i*LW +: LW] = la - lb;
      assign gt_v[g][i*LW +: LW]  = {LW{$signed(la) > $signed(lb)}};
      assign eq_v[g][i*LW +: LW]  = {LW{la == lb}};
    end
  end

  wire lane_ok = (lane_sel != 2'd3);
  logic [DW-1:0] nxt;
  logic          bad;

  always_comb begin
    nxt = '0;
    bad = 1'b0;
    case (op)
      OP_ADD:  if (lane_ok) nxt = add_v[lane_sel]; else bad = 1'b1;
      OP_SUB:  if (lane_ok) nxt = sub_v[lane_sel]; else bad = 1'b1;
      OP_GT:   if (lane_ok) nxt = gt_v[lane_sel];  else bad = 1'b1;
      OP_EQ:   if (lane_ok) nxt = eq_v[lane_sel];  else bad = 1'b1;
      OP_AND:  nxt = src_a & src_b;
      OP_OR:   nxt = src_a | src_b;
      OP_XOR:  nxt = src_a ^ src_b;
      OP_NOR:  nxt = ~(src_a | src_b);
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_we     <= 1'b0;
      res_idx    <= '0;
      res_data   <= '0;
      illegal_op <= 1'b0;
    end else begin
      res_valid  <= in_valid;
      res_we     <= in_valid && (dst_idx != '0);
      illegal_op <= in_valid && bad;
      if (in_valid) begin
        res_idx  <= dst_idx;
        res_data <= nxt;
      end
    end
  end

  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  // R1
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid && !res_we && !illegal_op);
  // R8
  dst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dst_idx == '0 |=> !res_we);
  // R8
  we_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_valid && res_idx != '0);
  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> res_valid && res_data == '0);
  // R10
  idx_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_idx == $past(dst_idx));
endmodule

// File: tb/test_simd_lane_alu.sv
module test_simd_lane_alu;
  localparam int PERIOD = 10;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] lane_sel = '0;
  logic [4:0] dst_idx = '0;
  logic [127:0] src_a = '0, src_b = '0;
  logic res_valid, res_we, illegal_op;
  logic [4:0] res_idx;
  logic [127:0] res_data;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  simd_lane_alu i_simd_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
    .dst_idx(dst_idx), .src_a(src_a), .src_b(src_b), .res_valid(res_valid),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data), .illegal_op(illegal_op));

  // {op, lane_sel, a, b, expected}
  localparam logic [389:0] VT [NV] = '{
    {4'd0, 2'd0, {16{8'hFF}}, {16{8'h01}}, 128'h0},
    {4'd0, 2'd1, {8{16'h7FFF}}, {8{16'h0001}}, {8{16'h8000}}},
    {4'd0, 2'd2, {4{32'hFFFFFFFF}}, {4{32'h2}}, {4{32'h1}}},
    {4'd1, 2'd0, 128'h0, {16{8'h01}}, {16{8'hFF}}},
    {4'd1, 2'd1, {8{16'h1234}}, {8{16'h0234}}, {8{16'h1000}}},
    {4'd1, 2'd2, 128'h0, {4{32'h1}}, {128{1'b1}}},
    {4'd2, 2'd3, {32{4'hC}}, {32{4'hA}}, {32{4'h8}}},
    {4'd3, 2'd0, {32{4'hC}}, {32{4'hA}}, {32{4'hE}}},
    {4'd4, 2'd1, {32{4'hC}}, {32{4'hA}}, {32{4'h6}}},
    {4'd5, 2'd2, {32{4'hC}}, {32{4'hA}}, {32{4'h1}}},
    {4'd6, 2'd0, {8{8'h01, 8'h80}}, {8{8'hFF, 8'h7F}}, {8{16'hFF00}}},
    {4'd6, 2'd1, {8{16'h0005}}, {8{16'h0005}}, 128'h0},
    {4'd6, 2'd2, {2{32'h7FFFFFFF, 32'h80000000}}, {2{32'h80000000, 32'h7FFFFFFF}},
                 {2{32'hFFFFFFFF, 32'h0}}},
    {4'd7, 2'd0, {16{8'h5A}}, {8{8'h5A, 8'h5B}}, {8{8'hFF, 8'h00}}},
    {4'd7, 2'd1, {8{16'h1234}}, {8{16'h1234}}, {128{1'b1}}},
    {4'd7, 2'd2, {4{32'h1}}, {2{32'h1, 32'h2}}, {2{32'hFFFFFFFF, 32'h0}}}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [1:0] ls, input logic [4:0] d,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    op = o; lane_sel = ls; dst_idx = d; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2 add";
      4'd1: return "R3 sub";
      4'd6: return "R5 gt";
      4'd7: return "R6 eq";
      default: return "R4 bitwise";
    endcase
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 2);
    // R1 reset state
    check("R1 reset valid", {127'b0, res_valid}, 128'h0);
    check("R1 reset data", res_data, 128'h0);
    check("R1 reset flags", {125'b0, res_we, illegal_op, |res_idx}, 128'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      issue(VT[k][389:386], VT[k][385:384], 5'd1, VT[k][383:256], VT[k][255:128]);
      check(tag_of(VT[k][389:386]), res_data, VT[k][127:0]);
      check("R1 valid after request", {126'b0, res_valid, res_we}, 128'h3);
    end

    // R7 lane size 3 makes a lane operation illegal
    issue(4'd0, 2'd3, 5'd4, {16{8'h11}}, {16{8'h22}});
    check("R7 lane3 add data", res_data, 128'h0);
    check("R7 lane3 add flag", {127'b0, illegal_op}, 128'h1);

    // R9 unsupported op code, then flag clears on the next legal request
    issue(4'd9, 2'd0, 5'd7, {128{1'b1}}, {128{1'b1}});
    check("R9 illegal data", res_data, 128'h0);
    check("R9 illegal flag and we", {126'b0, illegal_op, res_we}, 128'h3);
    issue(4'd3, 2'd0, 5'd7, 128'h5, 128'hA);
    check("R9 flag one cycle", {127'b0, illegal_op}, 128'h0);
    check("R4 or after illegal", res_data, 128'hF);

    // R8 destination zero
    issue(4'd0, 2'd0, 5'd0, 128'h1, 128'h1);
    check("R8 dst0 we", {126'b0, res_valid, res_we}, 128'h2);

    // R10 index echo
    issue(4'd2, 2'd0, 5'd31, 128'h0, 128'h0);
    check("R10 idx", {123'b0, res_idx}, 128'd31);

    // R1 idle cycle
    @(negedge clk);
    check("R1 idle valid", {126'b0, res_valid, res_we}, 128'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule